// File: doc/BRIEF.md
# Clock Tuning Control Register Bank

This block stores the clock tuning settings for four card-interface controllers. Each controller has two words: one for its drive clock and one for its sample clock. Every word selects a phase shift, a delay-line tap count, and whether the delay line is used at all. A simple register bus reads and writes the words. The current field values are also driven out in parallel to the phase and delay hardware, so that hardware always follows the stored settings.

Writes carry their own bit-enable mask. The upper half of the 32-bit write data enables the bits of the lower half one for one. Software can therefore change a single field, such as the tap count, without first reading the word. An access to an address that maps to no word changes nothing, reads back zero and raises a one-cycle error pulse.

Top module: `clk_tune_regs`

## Requirements
- R1: Controller c (0..3) has its drive-clock word at byte address 0x200 + 8*c and its sample-clock word at 0x200 + 8*c + 4. A read returns that word's stored contents.
- R2: On a write, stored bit n (n = 0..15) takes wdata bit n only when wdata bit n+16 is 1. Otherwise it keeps its old value. A write with wdata[31:16] = 0 changes nothing.
- R3: Read data bits 31:16 are always zero, whatever mask the stored value was written with.
- R4: After reset every stored bit is 0. This gives phase 0, tap count 0 and phase-only mode on every output.
- R5: Drive-clock word layout: the phase is in bits 2:1, the tap count in bits 10:3 and the mode bit at bit 11. Phase codes 0..3 mean 0, 90, 180 and 270 degrees. Mode 1 means phase plus delay line, and mode 0 means phase only.
- R6: Sample-clock word layout: the phase is in bits 1:0, the tap count in bits 9:2 and the mode bit at bit 10. Phase codes and mode meaning are the same as in R5.
- R7: Controller c drives its fields on phase[2c+1:2c], delay[8c+7:8c] and mode[c]. These outputs keep their value up to the clock edge that accepts a write and show the new value right after that edge.
- R8: An access whose address is not one of the eight word addresses changes no stored bit and returns zero read data. This includes addresses that are not multiples of 4. In the cycle after it is accepted, err_o is 1 for exactly one cycle.
- R9: rdata_o is captured on the edge that accepts a read and holds until the next read, even if the word is written in between.
- R10: A read that follows a write returns the value the write left in the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | [31:16] bit-enable mask, [15:0] data |
| rdata_o | output | 32 | Read data, registered |
| err_o | output | 1 | One-cycle pulse after an unmapped access |
| drv_phase_o | output | 8 | Drive-clock phase, 2 bits per controller |
| drv_delay_o | output | 32 | Drive-clock tap count, 8 bits per controller |
| drv_mode_o | output | 4 | Drive-clock delay-line enable per controller |
| smp_phase_o | output | 8 | Sample-clock phase, 2 bits per controller |
| smp_delay_o | output | 32 | Sample-clock tap count, 8 bits per controller |
| smp_mode_o | output | 4 | Sample-clock delay-line enable per controller |

## Verification
Partial masks are the first target. The bench writes only the tap-count bits and checks that the phase and mode keep their old values. A design that ignored the mask, or applied it to the wrong half, would clear or corrupt those fields. The two word layouts differ by one bit position, so the bench writes a known field pattern to each clock type and checks every exported field. A decoder that swapped the types would show a tap count shifted by one. Unmapped and unaligned addresses must leave all eight words untouched and give exactly one error cycle, where a loose decoder would alias onto a real word. The bench also writes to a word after reading it and checks that the read data does not change, which a combinational read path would fail.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int WORD_W  = 16;
  localparam int BUS_W   = 2 * WORD_W;
  localparam int PHASE_W = 2;
  localparam int DELAY_W = 8;

  // clk_type 0: drive clock, 1: sample clock
  function automatic int phase_lsb(input int clk_type);
    return (clk_type != 0) ? 0 : 1;
  endfunction

  function automatic int delay_lsb(input int clk_type);
    return (clk_type != 0) ? 2 : 3;
  endfunction

  function automatic int mode_bit(input int clk_type);
    return (clk_type != 0) ? 10 : 11;
  endfunction
endpackage

// File: rtl/tune_addr_dec.sv
module tune_addr_dec #(
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200,
  parameter int N_WORDS   = 8,
  localparam int IDX_W    = $clog2(N_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(N_WORDS * 4);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off   = addr_i - BASE;
    hit_o = (addr_i >= BASE) && (off < SPAN) && (off[1:0] == 2'b00);
    idx_o = off[IDX_W+1:2];
  end
endmodule

// File: rtl/tune_word.sv
module tune_word
  import tune_pkg::*;
#(
  parameter int CLK_TYPE = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic [WORD_W-1:0]  wmask_i,
  output logic [WORD_W-1:0]  q_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [DELAY_W-1:0] delay_o,
  output logic               mode_o
);
  localparam int PL = phase_lsb(CLK_TYPE);
  localparam int DL = delay_lsb(CLK_TYPE);
  localparam int MB = mode_bit(CLK_TYPE);

  logic [WORD_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= (q & ~wmask_i) | (wdata_i & wmask_i);
  end

  assign q_o     = q;
  assign phase_o = q[PL +: PHASE_W];
  assign delay_o = q[DL +: DELAY_W];
  assign mode_o  = q[MB];

  // R2
  masked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (((q ^ $past(q)) & ~$past(wmask_i)) == '0));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q));
endmodule

// File: rtl/clk_tune_regs.sv
module clk_tune_regs
  import tune_pkg::*;
#(
  parameter int N_CTRL    = 4,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200,
  localparam int N_WORDS  = 2 * N_CTRL,
  localparam int IDX_W    = $clog2(N_WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BUS_W-1:0]          wdata_i,
  output logic [BUS_W-1:0]          rdata_o,
  output logic                      err_o,
  output logic [N_CTRL*PHASE_W-1:0] drv_phase_o,
  output logic [N_CTRL*DELAY_W-1:0] drv_delay_o,
  output logic [N_CTRL-1:0]         drv_mode_o,
  output logic [N_CTRL*PHASE_W-1:0] smp_phase_o,
  output logic [N_CTRL*DELAY_W-1:0] smp_delay_o,
  output logic [N_CTRL-1:0]         smp_mode_o
);
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [N_WORDS-1:0] wr_sel;
  logic [WORD_W-1:0]  q_w  [N_WORDS];
  logic [PHASE_W-1:0] ph_w [N_WORDS];
  logic [DELAY_W-1:0] dl_w [N_WORDS];
  logic [N_WORDS-1:0] md_w;
  logic [BUS_W-1:0]   rdata_q;
  logic               err_q;

  tune_addr_dec #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .N_WORDS(N_WORDS)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .idx_o(idx)
  );

  always_comb begin
    for (int w = 0; w < N_WORDS; w++)
      wr_sel[w] = req_i && we_i && hit && (idx == IDX_W'(w));
  end

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
    for (genvar t = 0; t < 2; t++) begin : g_type
      localparam int W = 2 * c + t;
      tune_word #(.CLK_TYPE(t)) u_word (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_sel[W]),
        .wdata_i(wdata_i[WORD_W-1:0]), .wmask_i(wdata_i[BUS_W-1:WORD_W]),
        .q_o(q_w[W]), .phase_o(ph_w[W]), .delay_o(dl_w[W]), .mode_o(md_w[W])
      );
      if (t == 0) begin : g_drv
        assign drv_phase_o[c*PHASE_W +: PHASE_W] = ph_w[W];
        assign drv_delay_o[c*DELAY_W +: DELAY_W] = dl_w[W];
        assign drv_mode_o[c]                     = md_w[W];
      end else begin : g_smp
        assign smp_phase_o[c*PHASE_W +: PHASE_W] = ph_w[W];
        assign smp_delay_o[c*DELAY_W +: DELAY_W] = dl_w[W];
        assign smp_mode_o[c]                     = md_w[W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= req_i && !hit;
      if (req_i && !we_i)
        rdata_q <= hit ? {{(BUS_W-WORD_W){1'b0}}, q_w[idx]} : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R8
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && !hit));
  // R7
  drv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(drv_delay_o) && $stable(drv_phase_o) && $stable(drv_mode_o)));
  // R7
  smp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(smp_delay_o) && $stable(smp_phase_o) && $stable(smp_mode_o)));
  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: tb/clk_tune_regs_bench.sv
`timescale 1ns/1ps
module clk_tune_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [7:0]  drv_ph, smp_ph;
  logic [31:0] drv_dl, smp_dl;
  logic [3:0]  drv_md, smp_md;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] m [8];

  always #4 clk = ~clk;

  clk_tune_regs u_clk_tune_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .drv_phase_o(drv_ph), .drv_delay_o(drv_dl), .drv_mode_o(drv_md),
    .smp_phase_o(smp_ph), .smp_delay_o(smp_dl), .smp_mode_o(smp_md)
  );

  function automatic logic [11:0] waddr(input int c, input int t);
    return 12'(32'h200 + c * 8 + t * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // access, then sample 1 ns after the accepting edge
  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic mwrite(input int c, input int t, input logic [31:0] d);
    int i = c * 2 + t;
    m[i] = (m[i] & ~d[31:16]) | (d[15:0] & d[31:16]);
    bus(1'b1, waddr(c, t), d);
  endtask

  task automatic check_fields(input string tag);
    for (int c = 0; c < 4; c++) begin
      logic [15:0] d = m[c*2];
      logic [15:0] s = m[c*2+1];
      chk({tag, " R5 drv phase"}, 32'(drv_ph[c*2 +: 2]), 32'(d[2:1]));
      chk({tag, " R5 drv delay"}, 32'(drv_dl[c*8 +: 8]), 32'(d[10:3]));
      chk({tag, " R5 drv mode"},  32'(drv_md[c]),       32'(d[11]));
      chk({tag, " R6 smp phase"}, 32'(smp_ph[c*2 +: 2]), 32'(s[1:0]));
      chk({tag, " R6 smp delay"}, 32'(smp_dl[c*8 +: 8]), 32'(s[9:2]));
      chk({tag, " R6 smp mode"},  32'(smp_md[c]),       32'(s[10]));
    end
  endtask

  task automatic check_reads(input string tag);
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++) begin
        bus(1'b0, waddr(c, t), 32'h0);
        chk({tag, " R1 R10 readback"}, rdata, {16'h0, m[c*2+t]});
      end
  endtask

  task automatic t_reset();
    chk("R4 rdata at reset", rdata, 32'h0);
    chk("R4 err at reset", 32'(err), 32'h0);
    check_fields("R4 reset");
    check_reads("R4 reset");
  endtask

  task automatic t_drive_layout();
    // phase 3, taps 0xA5, mode 1 on controller 1 drive word
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = waddr(1, 0); wdata = 32'hFFFF_0D2E;
    #1 chk("R7 drv delay before edge", 32'(drv_dl[15:8]), 32'h0);
    m[2] = 16'h0D2E;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
    chk("R7 R5 drv delay after edge", 32'(drv_dl[15:8]), 32'hA5);
    chk("R5 drv phase c1", 32'(drv_ph[3:2]), 32'h3);
    chk("R5 drv mode c1", 32'(drv_md[1]), 32'h1);
    check_fields("drv layout");
    bus(1'b0, waddr(1, 0), 32'h0);
    chk("R3 upper read bits", rdata, 32'h0000_0D2E);
  endtask

  task automatic t_sample_layout();
    // phase 2, taps 0x3C, mode 1 on controller 2 sample word
    mwrite(2, 1, 32'hFFFF_04F2);
    chk("R6 smp phase c2", 32'(smp_ph[5:4]), 32'h2);
    chk("R6 smp delay c2", 32'(smp_dl[23:16]), 32'h3C);
    chk("R6 smp mode c2", 32'(smp_md[2]), 32'h1);
    check_fields("smp layout");
  endtask

  task automatic t_masked();
    mwrite(1, 0, 32'h07F8_0000);  // clear taps only
    chk("R2 taps cleared", 32'(drv_dl[15:8]), 32'h0);
    chk("R2 phase kept", 32'(drv_ph[3:2]), 32'h3);
    chk("R2 mode kept", 32'(drv_md[1]), 32'h1);
    mwrite(1, 0, 32'h0000_FFFF);  // empty mask
    chk("R2 empty mask", 32'(drv_dl[15:8]), 32'h0);
    mwrite(2, 1, 32'h0003_0001);  // phase only
    chk("R2 smp phase only", 32'(smp_ph[5:4]), 32'h1);
    chk("R2 smp taps kept", 32'(smp_dl[23:16]), 32'h3C);
    check_fields("masked");
    check_reads("masked");
  endtask

  task automatic t_all_words();
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++)
        mwrite(c, t, {16'hFFFF, 16'(16'h1111 * (c * 2 + t + 1) ^ 16'h5A5A)});
    check_fields("all words");
    check_reads("all words");
  endtask

  task automatic t_bad_addr();
    logic [11:0] bad [5] = '{12'h1FC, 12'h220, 12'h202, 12'h000, 12'h207};
    for (int k = 0; k < 5; k++) begin
      bus(1'b1, bad[k], 32'hFFFF_FFFF);
      chk("R8 err after bad write", 32'(err), 32'h1);
      @(posedge clk); #1;
      chk("R8 err one cycle", 32'(err), 32'h0);
      bus(1'b0, bad[k], 32'h0);
      chk("R8 bad read zero", rdata, 32'h0);
      chk("R8 err after bad read", 32'(err), 32'h1);
    end
    bus(1'b0, waddr(0, 0), 32'h0);
    chk("R8 no err on good read", 32'(err), 32'h0);
    check_fields("bad addr");
    check_reads("bad addr");
  endtask

  task automatic t_read_hold();
    logic [31:0] held;
    bus(1'b0, waddr(3, 1), 32'h0);
    held = {16'h0, m[7]};
    chk("R9 read value", rdata, held);
    mwrite(3, 1, 32'hFFFF_0123);
    @(posedge clk); #1;
    chk("R9 rdata held across write", rdata, held);
    bus(1'b0, waddr(3, 1), 32'h0);
    chk("R10 read after write", rdata, 32'h0000_0123);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_drive_layout();
    t_sample_layout();
    t_masked();
    t_all_words();
    t_bad_addr();
    t_read_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule